// File: doc/BRIEF.md
# Receive Packet Class Scheduler

This block sits between a receive packet buffer and the application logic that consumes transaction packets. The buffer writes packet descriptors, each 136 bits wide, into one of three class queues: posted, non-posted and completion. Each descriptor comes with a payload length in dwords. The scheduler picks one queued descriptor at a time and offers it to the application through a request/acknowledge handshake. The descriptor is split into an 8-bit top segment, a 64-bit middle segment and a 64-bit low segment.

The application answers each offer in one of three ways. It can accept the packet, drop it, or send it back to be offered again later. After an accept, a packet with a payload moves through a 64-bit data phase, with byte enables and a stall input. Accepting or dropping a packet produces a one-cycle credit-release pulse. The pulse carries the class and the data credits the packet used. The application can also hold off the whole non-posted class. During the hold the other two classes are served. When the hold ends, the non-posted packets that built up are drained first.

Top module: `rx_class_sched`

## Requirements
- R1: After reset, `dsc_req`, `cr_valid` and `pl_valid` are low and all three full flags are low.
- R2: Once `dsc_req` rises, it stays high, and the descriptor and `dsc_class` stay unchanged, until the cycle in which `dsc_ack`, `dsc_drop` or `dsc_again` is sampled high.
- R3: The class codes are posted = 2'b00, non-posted = 2'b01 and completion = 2'b10. With no hold active, the non-empty classes are served round-robin in the order posted, completion, non-posted. After reset the first turn goes to posted. Each class is served in arrival order.
- R4: In the cycle after an accept or a drop, `cr_valid` pulses for exactly one cycle. `cr_class` carries the packet's class and `cr_data` carries ceil(length/4).
- R5: A retry (`dsc_again`) produces no credit pulse and leaves the descriptor at the head of its queue. The descriptor is offered again after the other classes have had their round-robin turn.
- R6: While `np_hold` is high, no non-posted descriptor is offered. Posted and completion descriptors are still served.
- R7: After `np_hold` falls, the non-posted descriptors queued during the hold are offered before any posted or completion descriptor, until the non-posted queue is empty.
- R8: `dsc_more` is high exactly when the length is non-zero. An accept of such a packet starts a data phase of ceil(length/2) beats. A beat moves in a cycle when `pl_stall` is low, and `pl_valid` is high in that cycle. `pl_be` is 8'hFF on every beat except the last beat of an odd length, which has 8'h0F. A dropped packet has no data phase.
- R9: A class's full flag is high when its queue holds DEPTH (8) descriptors. A write into a full queue is discarded.
- R10: After a zero-length packet is accepted, `dsc_req` is low for exactly one cycle and then rises again if any eligible descriptor is queued.
- R11: Only one descriptor is outstanding at a time. `dsc_req` stays low throughout a data phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Descriptor write strobe from the buffer |
| wr_class | input | 2 | Class of the written descriptor |
| wr_len | input | LEN_W | Payload length in dwords, 0 = no payload |
| wr_desc | input | 136 | Descriptor contents |
| full_p | output | 1 | Posted queue full |
| full_np | output | 1 | Non-posted queue full |
| full_cpl | output | 1 | Completion queue full |
| dsc_req | output | 1 | Descriptor offered |
| dsc_class | output | 2 | Class of the offered descriptor |
| dsc_hi | output | 8 | Descriptor bits 135:128 |
| dsc_mid | output | 64 | Descriptor bits 127:64 |
| dsc_lo | output | 64 | Descriptor bits 63:0 |
| dsc_more | output | 1 | Payload follows the descriptor |
| dsc_ack | input | 1 | Accept the offered descriptor |
| dsc_drop | input | 1 | Drop the offered descriptor |
| dsc_again | input | 1 | Retry the offered descriptor later |
| np_hold | input | 1 | Hold off the non-posted class |
| pl_stall | input | 1 | Application cannot take a beat this cycle |
| pl_valid | output | 1 | Payload beat valid |
| pl_data | output | 64 | Payload beat |
| pl_be | output | 8 | Byte enables of the beat |
| src_data | input | 64 | Payload word from the buffer |
| src_pop | output | 1 | Buffer payload word consumed |
| cr_valid | output | 1 | Credit-release pulse |
| cr_class | output | 2 | Class of the released credits |
| cr_data | output | LEN_W-1 | Data credits released, in 4-dword units |

## Verification
The assertions assume that the application raises at most one of accept, drop and retry in a cycle, and only while `dsc_req` is high. They also assume that `np_hold` is driven to a known level from reset onward. The bench pulses each response for exactly one cycle, and only at a falling edge after it has seen the request. It keeps `np_hold` low except inside the hold scenario, where the hold is dropped at a chosen point. It never writes the unused class code 2'b11.

// File: rtl/rx_class_sched.sv
module rx_class_sched #(
  parameter int DEPTH = 8,
  parameter int LEN_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  input  logic [1:0]        wr_class,
  input  logic [LEN_W-1:0]  wr_len,
  input  logic [135:0]      wr_desc,
  output logic              full_p,
  output logic              full_np,
  output logic              full_cpl,
  output logic              dsc_req,
  output logic [1:0]        dsc_class,
  output logic [7:0]        dsc_hi,
  output logic [63:0]       dsc_mid,
  output logic [63:0]       dsc_lo,
  output logic              dsc_more,
  input  logic              dsc_ack,
  input  logic              dsc_drop,
  input  logic              dsc_again,
  input  logic              np_hold,
  input  logic              pl_stall,
  output logic              pl_valid,
  output logic [63:0]       pl_data,
  output logic [7:0]        pl_be,
  input  logic [63:0]       src_data,
  output logic              src_pop,
  output logic              cr_valid,
  output logic [1:0]        cr_class,
  output logic [LEN_W-2:0]  cr_data
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [1:0] C_P = 2'd0, C_NP = 2'd1, C_CPL = 2'd2;

  typedef enum logic [1:0] {S_IDLE, S_REQ, S_DATA} st_t;

  logic [135:0]     q_desc [4][DEPTH];
  logic [LEN_W-1:0] q_len  [4][DEPTH];
  logic [AW-1:0]    wp [4];
  logic [AW-1:0]    rp [4];
  logic [CW-1:0]    cnt [4];
  logic [3:0]       push, pop, nz;

  st_t              st;
  logic [1:0]       cur, last;
  logic             boost, odd;
  logic [LEN_W-1:0] beats;

  logic [135:0]     hd_desc;
  logic [LEN_W-1:0] hd_len;
  logic             pick_any;
  logic [1:0]       pick_cls, pick_ord, o2;

  function automatic logic [1:0] ord2cls(input logic [1:0] o);
    case (o)
      2'd0:    return C_P;
      2'd1:    return C_CPL;
      default: return C_NP;
    endcase
  endfunction

  always_comb begin
    for (int c = 0; c < 4; c++) begin
      push[c] = (c < 3) && wr_valid && (wr_class == 2'(c)) && (cnt[c] != CW'(DEPTH));
      pop[c]  = (st == S_REQ) && (dsc_ack || dsc_drop) && (cur == 2'(c));
      nz[c]   = (cnt[c] != '0);
    end
  end

  assign full_p   = (cnt[0] == CW'(DEPTH));
  assign full_np  = (cnt[1] == CW'(DEPTH));
  assign full_cpl = (cnt[2] == CW'(DEPTH));

  always_ff @(posedge clk) begin
    for (int c = 0; c < 4; c++)
      if (push[c]) begin
        q_desc[c][wp[c]] <= wr_desc;
        q_len[c][wp[c]]  <= wr_len;
      end
  end

  always_ff @(posedge clk) begin
    for (int c = 0; c < 4; c++) begin
      if (!rst_n) begin
        wp[c]  <= '0;
        rp[c]  <= '0;
        cnt[c] <= '0;
      end else begin
        if (push[c]) wp[c] <= (wp[c] == AW'(DEPTH - 1)) ? '0 : wp[c] + 1'b1;
        if (pop[c])  rp[c] <= (rp[c] == AW'(DEPTH - 1)) ? '0 : rp[c] + 1'b1;
        case ({push[c], pop[c]})
          2'b10:   cnt[c] <= cnt[c] + 1'b1;
          2'b01:   cnt[c] <= cnt[c] - 1'b1;
          default: cnt[c] <= cnt[c];
        endcase
      end
    end
  end

  assign hd_desc = q_desc[cur][rp[cur]];
  assign hd_len  = q_len[cur][rp[cur]];

  always_comb begin
    pick_any = 1'b0;
    pick_cls = C_P;
    pick_ord = last;
    o2       = 2'd0;
    if (!np_hold && boost && nz[C_NP]) begin
      pick_any = 1'b1;
      pick_cls = C_NP;
      pick_ord = 2'd2;
    end else begin
      for (int k = 1; k < 4; k++) begin
        o2 = 2'((int'(last) + k) % 3);
        if (!pick_any && nz[ord2cls(o2)] && !(ord2cls(o2) == C_NP && np_hold)) begin
          pick_any = 1'b1;
          pick_cls = ord2cls(o2);
          pick_ord = o2;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      cur      <= C_P;
      last     <= 2'd2;
      boost    <= 1'b0;
      odd      <= 1'b0;
      beats    <= '0;
      cr_valid <= 1'b0;
      cr_class <= C_P;
      cr_data  <= '0;
    end else begin
      cr_valid <= 1'b0;
      if (np_hold && nz[C_NP]) boost <= 1'b1;
      else if (!nz[C_NP])      boost <= 1'b0;
      case (st)
        S_IDLE: if (pick_any) begin
          st   <= S_REQ;
          cur  <= pick_cls;
          last <= pick_ord;
        end
        S_REQ: begin
          if (dsc_ack || dsc_drop) begin
            cr_valid <= 1'b1;
            cr_class <= cur;
            cr_data  <= {1'b0, hd_len[LEN_W-1:2]} + (LEN_W-1)'(|hd_len[1:0]);
            if (dsc_ack && hd_len != '0) begin
              st    <= S_DATA;
              beats <= {1'b0, hd_len[LEN_W-1:1]} + LEN_W'(hd_len[0]);
              odd   <= hd_len[0];
            end else begin
              st <= S_IDLE;
            end
          end else if (dsc_again) begin
            st <= S_IDLE;
          end
        end
        S_DATA: if (!pl_stall) begin
          beats <= beats - 1'b1;
          if (beats == LEN_W'(1)) st <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign dsc_req   = (st == S_REQ);
  assign dsc_class = cur;
  assign dsc_hi    = hd_desc[135:128];
  assign dsc_mid   = hd_desc[127:64];
  assign dsc_lo    = hd_desc[63:0];
  assign dsc_more  = (hd_len != '0);
  assign pl_valid  = (st == S_DATA) && !pl_stall;
  assign pl_data   = src_data;
  assign pl_be     = (beats == LEN_W'(1) && odd) ? 8'h0F : 8'hFF;
  assign src_pop   = pl_valid;

  p_hold_stable_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (dsc_req && !dsc_ack && !dsc_drop && !dsc_again) |=>
      (dsc_req && $stable({dsc_hi, dsc_mid, dsc_lo}) && $stable(dsc_class)));

  p_credit_after_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cr_valid |-> $past(dsc_req && (dsc_ack || dsc_drop)));

  p_credit_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cr_valid |=> !cr_valid || $past(dsc_req && (dsc_ack || dsc_drop)));

  p_no_np_in_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(dsc_req) && dsc_class == C_NP) |-> !$past(np_hold));

  p_full_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (full_p && wr_valid && wr_class == C_P && !(dsc_req && dsc_class == C_P && (dsc_ack || dsc_drop)))
      |=> full_p);

  p_single_out_r11: assert property (@(posedge clk) disable iff (!rst_n)
    pl_valid |-> !dsc_req);

  p_retry_nocredit_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (dsc_req && dsc_again && !dsc_ack && !dsc_drop) |=> (!cr_valid && !dsc_req));
endmodule

// File: tb/rx_class_sched_bench.sv
module rx_class_sched_bench;
  localparam int LEN_W = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_valid = 1'b0;
  logic [1:0] wr_class = '0;
  logic [LEN_W-1:0] wr_len = '0;
  logic [135:0] wr_desc = '0;
  logic full_p, full_np, full_cpl;
  logic dsc_req, dsc_more;
  logic [1:0] dsc_class;
  logic [7:0] dsc_hi;
  logic [63:0] dsc_mid, dsc_lo;
  logic dsc_ack = 1'b0, dsc_drop = 1'b0, dsc_again = 1'b0;
  logic np_hold = 1'b0, pl_stall = 1'b0;
  logic pl_valid, src_pop, cr_valid;
  logic [63:0] pl_data;
  logic [63:0] src_data = '0;
  logic [7:0] pl_be;
  logic [1:0] cr_class;
  logic [LEN_W-2:0] cr_data;

  int nrun = 0;
  int nfail = 0;

  always #5 clk = ~clk;

  rx_class_sched #(.DEPTH(8), .LEN_W(LEN_W)) u_rx_class_sched (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_class(wr_class),
    .wr_len(wr_len), .wr_desc(wr_desc), .full_p(full_p), .full_np(full_np),
    .full_cpl(full_cpl), .dsc_req(dsc_req), .dsc_class(dsc_class),
    .dsc_hi(dsc_hi), .dsc_mid(dsc_mid), .dsc_lo(dsc_lo), .dsc_more(dsc_more),
    .dsc_ack(dsc_ack), .dsc_drop(dsc_drop), .dsc_again(dsc_again),
    .np_hold(np_hold), .pl_stall(pl_stall), .pl_valid(pl_valid),
    .pl_data(pl_data), .pl_be(pl_be), .src_data(src_data), .src_pop(src_pop),
    .cr_valid(cr_valid), .cr_class(cr_class), .cr_data(cr_data));

  localparam logic [1:0] TV_CLS [6] = '{2'd0, 2'd0, 2'd2, 2'd1, 2'd1, 2'd2};
  localparam int TV_LEN [6] = '{0, 4, 2, 0, 0, 5};
  localparam int EXP_ORD [6] = '{0, 2, 3, 1, 5, 4};

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    nrun++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic push(input logic [1:0] c, input int len, input int id);
    wr_valid = 1'b1;
    wr_class = c;
    wr_len   = LEN_W'(len);
    wr_desc  = {6'd0, c, ~64'(id), 64'(id)};
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic wait_req(output bit got);
    got = 1'b0;
    for (int i = 0; i < 100; i++) begin
      if (dsc_req) begin
        got = 1'b1;
        return;
      end
      @(negedge clk);
    end
  endtask

  task automatic serve(input int id, input int len, input logic [1:0] c,
                       input bit b2b, input bit drop_hold, input bit stall_first,
                       input string tag);
    bit got;
    int nb;
    wait_req(got);
    chk(got, tag, "request seen", 64'(got), 64'd1);
    if (!got) return;
    chk(dsc_lo == 64'(id), tag, "descriptor id", dsc_lo, 64'(id));
    chk(dsc_mid == ~64'(id), tag, "middle segment", dsc_mid, ~64'(id));
    chk(dsc_class == c, tag, "class", 64'(dsc_class), 64'(c));
    chk(dsc_more == (len != 0), "R8", "data-follows flag", 64'(dsc_more), 64'(len != 0));
    @(negedge clk);
    chk(dsc_req && dsc_lo == 64'(id), "R2", "held until answered", dsc_lo, 64'(id));
    dsc_ack = 1'b1;
    @(negedge clk);
    dsc_ack = 1'b0;
    if (drop_hold) np_hold = 1'b0;
    chk(!dsc_req, "R11", "request dropped after accept", 64'(dsc_req), 64'd0);
    chk(cr_valid, "R4", "credit pulse", 64'(cr_valid), 64'd1);
    chk(cr_class == c, "R4", "credit class", 64'(cr_class), 64'(c));
    chk(cr_data == (LEN_W-1)'((len + 3) / 4), "R4", "credit count", 64'(cr_data), 64'((len + 3) / 4));
    nb = (len + 1) / 2;
    for (int b = 0; b < nb; b++) begin
      if (stall_first && b == 0) begin
        pl_stall = 1'b1;
        #1;
        chk(!pl_valid, "R8", "stall holds beat", 64'(pl_valid), 64'd0);
        @(negedge clk);
        pl_stall = 1'b0;
      end
      src_data = 64'hD0D0_0000_0000_0000 | 64'(id * 16 + b);
      #1;
      chk(pl_valid, "R8", "beat valid", 64'(pl_valid), 64'd1);
      chk(pl_data == src_data, "R8", "beat data", pl_data, src_data);
      chk(pl_be == ((b == nb - 1 && (len % 2) == 1) ? 8'h0F : 8'hFF), "R8", "byte enables",
          64'(pl_be), 64'((b == nb - 1 && (len % 2) == 1) ? 8'h0F : 8'hFF));
      chk(!dsc_req, "R11", "no request in data phase", 64'(dsc_req), 64'd0);
      @(negedge clk);
    end
    if (nb > 0) chk(!pl_valid, "R8", "data phase length", 64'(pl_valid), 64'd0);
    if (nb > 0) chk(!cr_valid, "R4", "single-cycle pulse", 64'(cr_valid), 64'd0);
    if (b2b && len == 0) begin
      @(negedge clk);
      chk(dsc_req, "R10", "next request after one idle cycle", 64'(dsc_req), 64'd1);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog (R1..R11 run): actual=timeout expected=finish");
    $display("  [TB] %0d tests run, %0d failed", nrun, nfail);
    $finish;
  end

  initial begin
    bit got;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!dsc_req, "R1", "request idle", 64'(dsc_req), 64'd0);
    chk(!cr_valid && !pl_valid, "R1", "pulses idle", 64'({cr_valid, pl_valid}), 64'd0);
    chk({full_p, full_np, full_cpl} == 3'b000, "R1", "full flags", 64'({full_p, full_np, full_cpl}), 64'd0);

    for (int i = 0; i < 6; i++) push(TV_CLS[i], TV_LEN[i], i);
    for (int e = 0; e < 6; e++)
      serve(EXP_ORD[e], TV_LEN[EXP_ORD[e]], TV_CLS[EXP_ORD[e]], e < 5, 1'b0, 1'b0, "R3");

    push(2'd1, 0, 20);
    wait_req(got);
    chk(dsc_lo == 64'd20, "R5", "first offer", dsc_lo, 64'd20);
    push(2'd0, 0, 21);
    chk(dsc_req && dsc_lo == 64'd20, "R2", "held across write", dsc_lo, 64'd20);
    dsc_again = 1'b1;
    @(negedge clk);
    dsc_again = 1'b0;
    chk(!dsc_req, "R5", "request withdrawn on retry", 64'(dsc_req), 64'd0);
    chk(!cr_valid, "R5", "no credit on retry", 64'(cr_valid), 64'd0);
    serve(21, 0, 2'd0, 1'b1, 1'b0, 1'b0, "R5");
    serve(20, 0, 2'd1, 1'b0, 1'b0, 1'b0, "R5");

    np_hold = 1'b1;
    push(2'd1, 0, 30);
    push(2'd1, 0, 31);
    for (int i = 0; i < 5; i++) begin
      chk(!dsc_req, "R6", "no non-posted offer in hold", 64'(dsc_req), 64'd0);
      @(negedge clk);
    end
    push(2'd0, 0, 33);
    push(2'd2, 0, 32);
    serve(33, 0, 2'd0, 1'b1, 1'b1, 1'b0, "R6");
    serve(30, 0, 2'd1, 1'b1, 1'b0, 1'b0, "R7");
    serve(31, 0, 2'd1, 1'b1, 1'b0, 1'b0, "R7");
    serve(32, 0, 2'd2, 1'b0, 1'b0, 1'b0, "R7");

    for (int i = 0; i < 8; i++) push(2'd0, 0, 40 + i);
    chk(full_p, "R9", "full after DEPTH writes", 64'(full_p), 64'd1);
    push(2'd0, 0, 48);
    chk(full_p && !full_np && !full_cpl, "R9", "flags after extra write",
        64'({full_p, full_np, full_cpl}), 64'b100);
    for (int i = 0; i < 8; i++) serve(40 + i, 0, 2'd0, i < 7, 1'b0, 1'b0, "R9");
    for (int i = 0; i < 10; i++) @(negedge clk);
    chk(!dsc_req, "R9", "write into full queue discarded", 64'(dsc_req), 64'd0);
    chk(!full_p, "R9", "full cleared", 64'(full_p), 64'd0);

    push(2'd0, 8, 50);
    wait_req(got);
    chk(dsc_lo == 64'd50 && dsc_more, "R8", "payload packet offered", dsc_lo, 64'd50);
    dsc_drop = 1'b1;
    @(negedge clk);
    dsc_drop = 1'b0;
    chk(cr_valid && cr_data == 9'd2, "R4", "credit on drop", 64'(cr_data), 64'd2);
    chk(!pl_valid, "R8", "no data phase on drop", 64'(pl_valid), 64'd0);
    @(negedge clk);
    chk(!pl_valid && !dsc_req && !cr_valid, "R8", "idle after drop",
        64'({pl_valid, dsc_req, cr_valid}), 64'd0);

    push(2'd2, 3, 60);
    serve(60, 3, 2'd2, 1'b0, 1'b0, 1'b1, "R8");

    $display("  [TB] %0d tests run, %0d failed", nrun, nfail);
    $finish;
  end
endmodule